// File: doc/BRIEF.md
# Multi-Mode Accumulator Load Unit

This block carries out one single-operand load into an accumulator. Memory is reached over a byte-wide synchronous read port with a 24-bit address. After a start request, the unit reads the instruction one byte at a time: first a one-byte opcode, then a three-byte field. It then resolves the operand in one of four ways and writes the result to the accumulator.

The four addressing modes are:
- the field itself, as an immediate value;
- a word in memory at the field address (direct);
- a word reached through a pointer held in memory (indirect);
- a general-purpose register named by the field.

Every 24-bit word is built from three consecutive byte reads, least significant byte first. The unit counts the bus bytes it moves for each instruction, so the cost of each mode can be seen at the port. The totals are 4 bytes for immediate and register mode, 7 for direct mode and 10 for indirect mode.

A host pulses start with the instruction address on `pc`, serves byte reads, and provides the register contents for the selector the unit drives. It then waits for the one-cycle completion pulse.

Top module: `acc_load_unit`

## Requirements
- R1: A synchronous reset clears the accumulator and the byte count to zero, keeps `done` and `mem_rd` low, and leaves the unit idle.
- R2: After start, the unit reads the opcode byte at `pc`, then the field bytes at `pc+1`, `pc+2` and `pc+3`. The field is assembled little-endian, so the byte at `pc+1` is bits 7:0.
- R3: Opcode bits 1:0 pick the mode: 00 immediate, 01 direct, 10 indirect, 11 register. Opcode bits 7:3 have no effect. In immediate mode the field itself is loaded and no operand bytes are read.
- R4: Opcode bit 2 applies to immediate mode only. When it is set, field bit 23 is copied into every accumulator bit above 23. When it is clear, those bits are zero.
- R5: Direct mode reads three bytes at field, field+1 and field+2, least significant byte first. The word is zero-extended into the accumulator.
- R6: Indirect mode first reads a three-byte little-endian pointer at field..field+2. It then reads the three data bytes at pointer..pointer+2 and zero-extends them into the accumulator.
- R7: Register mode drives `rf_sel` with the low bits of the field. It loads `rf_data` into the accumulator and reads no operand bytes.
- R8: While `mem_rd` is high and `mem_ready` is low, `mem_rd` and `mem_addr` hold their values. A byte is taken in a cycle where both `mem_rd` and `mem_ready` are high.
- R9: `done` is high for exactly one cycle. That cycle is the first one in which the accumulator shows its new value, and the accumulator changes at no other time.
- R10: `bus_bytes` drops to zero in the cycle after start is accepted. It then counts each byte taken, ending at 4 for immediate or register mode, 7 for direct mode and 10 for indirect mode.
- R11: A start pulse, or a change on `pc`, while an instruction is in progress has no effect on that instruction.
- R12: Address increments wrap modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an instruction; accepted only when idle |
| pc | input | 24 | Address of the opcode byte, captured at start |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_rdata | input | 8 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Read completes in this cycle |
| rf_sel | output | 3 | Register selector, low field bits |
| rf_data | input | ACC_W | Contents of the selected register |
| acc | output | ACC_W | Accumulator |
| done | output | 1 | One-cycle completion pulse |
| bus_bytes | output | 4 | Bytes moved by the current or last instruction |

## Verification
All four modes are driven with fields whose top bit is either set or clear, and with sign extension both on and off. This separates sign extension from zero-fill, and also shows that extension never applies to memory or register words. Random opcode upper bits and register fields with high bits set confirm that only the decoded bits count. Memory readiness is switched between always-ready and random stalls, so the held request and the byte order can be told apart from a design that assumes a single-cycle memory. The address trace checks pointer chaining and 24-bit wrap. A start pulse injected mid-instruction, with a changed `pc`, must leave the trace and the result unchanged.

// File: rtl/lu_pkg.sv
package lu_pkg;
  typedef enum logic [1:0] {
    AM_IMM = 2'b00,
    AM_DIR = 2'b01,
    AM_IND = 2'b10,
    AM_REG = 2'b11
  } amode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_FLD,
    S_PTR,
    S_OPD,
    S_EXEC
  } lu_state_t;

  typedef enum logic [1:0] {
    LD_FIELD,
    LD_REG,
    LD_MEM
  } ld_src_t;

  // state that follows the last byte of a three-byte phase
  function automatic lu_state_t after_phase(input lu_state_t s);
    case (s)
      S_FLD:   return S_EXEC;
      S_PTR:   return S_OPD;
      default: return S_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/lu_word_asm.sv
module lu_word_asm #(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] word_next
);
  // little-endian assembly: each new byte enters at the top and moves down
  assign word_next = {din, word[WORD_W-1:BYTE_W]};

  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= word_next;
  end
endmodule

// File: rtl/lu_beat_cnt.sv
module lu_beat_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lu_ctrl.sv
module lu_ctrl
  import lu_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 24,
  parameter int NBYTES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc,
  input  logic              mem_ready,
  input  logic [2:0]        opc_bits,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] word_next,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              accept,
  output logic              shift_en,
  output logic              load_en,
  output ld_src_t           load_src,
  output logic              sx
);
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  lu_state_t         st;
  amode_t            mode_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  idx;
  logic              last;
  logic              beat;

  assign last     = (idx == IDX_W'(NBYTES - 1));
  assign mem_rd   = (st == S_OPC) || (st == S_FLD) || (st == S_PTR) || (st == S_OPD);
  assign mem_addr = (st == S_OPC) ? pc_q : base + ADDR_W'(idx);
  assign beat     = mem_rd && mem_ready;
  assign accept   = (st == S_IDLE) && start;
  assign shift_en = beat && (st != S_OPC);
  assign load_en  = ((st == S_EXEC) && ((mode_q == AM_IMM) || (mode_q == AM_REG)))
                 || ((st == S_OPD) && mem_ready && last);
  assign load_src = (st == S_OPD) ? LD_MEM : ((mode_q == AM_REG) ? LD_REG : LD_FIELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      mode_q <= AM_IMM;
      sx     <= 1'b0;
      pc_q   <= '0;
      base   <= '0;
      idx    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pc_q <= pc;
          st   <= S_OPC;
        end
        S_OPC: if (mem_ready) begin
          mode_q <= amode_t'(opc_bits[1:0]);
          sx     <= opc_bits[2];
          base   <= pc_q + ADDR_W'(1);
          idx    <= '0;
          st     <= S_FLD;
        end
        S_FLD, S_PTR, S_OPD: if (mem_ready) begin
          if (last) begin
            idx <= '0;
            st  <= after_phase(st);
            if (st == S_PTR) base <= word_next[ADDR_W-1:0];
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_EXEC: begin
          base <= word[ADDR_W-1:0];
          case (mode_q)
            AM_DIR:  st <= S_OPD;
            AM_IND:  st <= S_PTR;
            default: st <= S_IDLE;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acc_load_unit.sv
module acc_load_unit
  import lu_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24,
  parameter int ACC_W  = 24,
  parameter int NREG   = 8,
  localparam int NBYTES = WORD_W / BYTE_W,
  localparam int RSEL_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CNT_W  = $clog2(3 * NBYTES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [RSEL_W-1:0] rf_sel,
  input  logic [ACC_W-1:0]  rf_data,
  output logic [ACC_W-1:0]  acc,
  output logic              done,
  output logic [CNT_W-1:0]  bus_bytes
);
  // word to accumulator width, optionally copying the top bit upward
  function automatic logic [ACC_W-1:0] widen(input logic [WORD_W-1:0] w, input logic ext);
    logic [ACC_W-1:0] r;
    r = '0;
    r[WORD_W-1:0] = w;
    for (int i = WORD_W; i < ACC_W; i++) r[i] = ext & w[WORD_W-1];
    return r;
  endfunction

  logic              beat;      // a byte is taken this cycle
  logic              accept;    // start accepted this cycle
  logic              shift_en;
  logic              load_en;   // accumulator written at this edge
  ld_src_t           load_src;
  logic              sx;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] word_next;
  logic [ACC_W-1:0]  load_val;

  assign beat   = mem_rd && mem_ready;
  assign rf_sel = word[RSEL_W-1:0];

  lu_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pc(pc), .mem_ready(mem_ready),
    .opc_bits(mem_rdata[2:0]), .word(word), .word_next(word_next),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .accept(accept), .shift_en(shift_en),
    .load_en(load_en), .load_src(load_src), .sx(sx)
  );

  lu_word_asm #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(mem_rdata),
    .word(word), .word_next(word_next)
  );

  lu_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(accept), .inc(beat), .cnt(bus_bytes)
  );

  always_comb begin
    case (load_src)
      LD_REG:  load_val = rf_data;
      LD_MEM:  load_val = widen(word_next, 1'b0);
      default: load_val = widen(word, sx);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= load_en;
      if (load_en) acc <= load_val;
    end
  end
endmodule

// File: rtl/lu_checker.sv
module lu_checker #(
  parameter int ADDR_W = 24,
  parameter int ACC_W  = 24,
  parameter int NBYTES = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              beat,
  input logic [ACC_W-1:0]  acc,
  input logic              done,
  input logic [CNT_W-1:0]  bus_bytes
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_rd && !done && acc == '0 && bus_bytes == '0));

  a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_acc_moves_with_done: assert property (@(posedge clk) disable iff (rst)
    (acc != $past(acc)) |-> done);

  a_r10_totals: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_bytes == CNT_W'(NBYTES + 1) || bus_bytes == CNT_W'(2 * NBYTES + 1)
              || bus_bytes == CNT_W'(3 * NBYTES + 1)));

  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    (bus_bytes != $past(bus_bytes)) |-> ($past(beat) || bus_bytes == '0));

  a_r11_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_rd);
endmodule

bind acc_load_unit lu_checker #(
  .ADDR_W(ADDR_W), .ACC_W(ACC_W), .NBYTES(NBYTES), .CNT_W(CNT_W)
) u_lu_checker (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .beat(beat), .acc(acc), .done(done), .bus_bytes(bus_bytes)
);

// File: tb/acc_load_unit_test.sv
module acc_load_unit_test;
  localparam int AW = 24;
  localparam int XW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic          mem_ready = 1'b0;
  logic [2:0]    rf_sel;
  logic [XW-1:0] rf_data;
  logic [XW-1:0] acc;
  logic          done;
  logic [3:0]    bus_bytes;

  logic [7:0]    mem [0:1023];
  logic [XW-1:0] regs [0:7];
  logic [AW-1:0] log_a [0:15];
  int            log_n = 0;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            rnd_ready = 1'b0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];
  assign rf_data   = regs[rf_sel];

  acc_load_unit #(.ACC_W(XW)) uut (
    .clk(clk), .rst(rst), .start(start), .pc(pc), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_sel(rf_sel), .rf_data(rf_data),
    .acc(acc), .done(done), .bus_bytes(bus_bytes)
  );

  task automatic chk(input bit ok, input string req, input logic [XW-1:0] act,
                     input logic [XW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] rd24(input logic [AW-1:0] a);
    logic [AW-1:0] a1 = a + 24'd1;
    logic [AW-1:0] a2 = a + 24'd2;
    return 24'(mem[a[9:0]]) + 24'(mem[a1[9:0]]) * 24'd256 + 24'(mem[a2[9:0]]) * 24'd65536;
  endfunction

  // bytes on the bus: one request per negedge, with ready chosen here
  initial begin
    forever begin
      @(negedge clk);
      mem_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
      #0.5;
      if (mem_rd && mem_ready && log_n < 16) begin
        log_a[log_n] = mem_addr;
        log_n++;
      end
    end
  end

  task automatic run(input logic [AW-1:0] ipc, input logic [7:0] opc,
                     input logic [23:0] fld, input bit poke, input string tag);
    logic [AW-1:0] ea [0:9];
    int            en;
    logic [XW-1:0] ex;
    logic [23:0]   ptr;
    int            waitc;
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] a = ipc + AW'(i);
      mem[a[9:0]] = (i == 0) ? opc : fld[8*(i-1) +: 8];
    end
    for (int i = 0; i < 4; i++) ea[i] = ipc + AW'(i);
    en = 4;
    case (opc[1:0])
      2'b00: ex = opc[2] ? {{8{fld[23]}}, fld} : {8'h00, fld};
      2'b01: begin
        for (int i = 0; i < 3; i++) ea[4+i] = fld + AW'(i);
        en = 7;
        ex = {8'h00, rd24(fld)};
      end
      2'b10: begin
        ptr = rd24(fld);
        for (int i = 0; i < 3; i++) begin
          ea[4+i] = fld + AW'(i);
          ea[7+i] = ptr + AW'(i);
        end
        en = 10;
        ex = {8'h00, rd24(ptr)};
      end
      default: ex = regs[fld[2:0]];
    endcase
    log_n = 0;
    pc    = ipc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(bus_bytes == 4'd0, {"R10 cleared at start ", tag}, XW'(bus_bytes), 0);
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      pc    = ipc ^ 24'h00F0F3;
      @(negedge clk);
      start = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 1000) begin
      @(negedge clk);
      waitc++;
    end
    chk(done == 1'b1, {"R9 done seen ", tag}, XW'(done), 1);
    chk(acc == ex, {"R3/R4/R5/R6/R7 result ", tag}, acc, ex);
    chk(bus_bytes == 4'(en), {"R10 byte total ", tag}, XW'(bus_bytes), XW'(en));
    begin
      bit ok = (log_n == en);
      logic [AW-1:0] bad_a = '0;
      logic [AW-1:0] bad_e = '0;
      for (int i = 0; i < en && i < log_n; i++)
        if (log_a[i] !== ea[i] && ok) begin
          ok = 1'b0; bad_a = log_a[i]; bad_e = ea[i];
        end
      if (log_n != en) begin bad_a = AW'(log_n); bad_e = AW'(en); end
      chk(ok, {"R2/R5/R6/R8/R11/R12 address trace ", tag}, XW'(bad_a), XW'(bad_e));
    end
    @(negedge clk);
    chk(done == 1'b0, {"R9 done one cycle ", tag}, XW'(done), 0);
    chk(acc == ex, {"R9 acc held ", tag}, acc, ex);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 8; i++) regs[i] = $urandom;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(acc == '0 && done == 1'b0, "R1 reset acc/done", acc, 0);
    chk(mem_rd == 1'b0 && bus_bytes == 4'd0, "R1 reset idle", XW'({mem_rd, bus_bytes}), 0);

    // directed corners, single-cycle memory
    run(24'h000100, 8'b0000_0100, 24'h800000, 1'b0, "imm sx neg");
    run(24'h000104, 8'b0000_0000, 24'h800000, 1'b0, "imm zx");
    run(24'h000108, 8'b1111_1100, 24'h7FFFFF, 1'b0, "imm sx pos high bits");
    run(24'h000110, 8'b0000_0101, 24'h000200, 1'b0, "direct");
    run(24'h000120, 8'b0000_0110, 24'h000300, 1'b0, "indirect");
    run(24'h000130, 8'b0000_0111, 24'hABCDE5, 1'b0, "register");
    run(24'hFFFFFE, 8'b0000_0001, 24'hFFFFFF, 1'b0, "R12 wrap");
    rnd_ready = 1'b1;
    run(24'h000140, 8'b0000_0110, 24'h000280, 1'b1, "R11 start while busy");
    run(24'h000150, 8'b0101_0001, 24'h000380, 1'b0, "R8 stalls direct");

    for (int k = 0; k < 40; k++) begin
      rnd_ready = k[0];
      run(24'($urandom), 8'($urandom), 24'($urandom), k % 5 == 0, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule